// File: doc/BRIEF.md
# Lowest-Index Buffer Allocator

This block keeps the occupancy of a pool of buffers (32 by default) and hands out free ones on demand. Every cycle a client may raise an allocation strobe, a release strobe with a buffer index, or both. For an allocation, the block presents the index of the lowest-numbered idle buffer in the same cycle. It marks that buffer busy at the next clock edge. When no buffer is idle, it refuses the request with a negative acknowledge.

A release clears the busy mark of the addressed buffer. Alongside the busy marks, the block keeps a count of occupied buffers. Releasing a buffer that is already idle does not change that count. If one buffer is both released and granted in the same cycle, the grant wins and the buffer stays busy.

The block has no state machine. Its only state is the per-buffer busy vector and the occupancy counter. The counter update is encoded as one of three named steps: hold, increment or decrement.

Top module: `buf_alloc_top`

## Requirements
- R1: After reset every buffer is idle, `busy_count` is 0, `nack` is low and `alloc_idx` is 0.
- R2: `nack` is high in a cycle exactly when `alloc_req` is high and `busy_count` equals the pool size. It is combinational.
- R3: While at least one buffer is idle, `alloc_idx` shows, in the same cycle, the lowest index whose busy mark is clear.
- R4: While every buffer is busy, `alloc_idx` is 0.
- R5: An allocation that is not refused, without a counted release, raises `busy_count` by one at the next edge.
- R6: A release of a busy buffer, without a granted allocation, lowers `busy_count` by one at the next edge. A release of an idle buffer leaves the count unchanged.
- R7: A release clears the busy mark of the buffer given by `free_idx`. If that buffer is then the lowest idle one, it is offered on `alloc_idx` from the next cycle.
- R8: When the granted buffer is also the target of a release in the same cycle, it ends the cycle busy.
- R9: A refused allocation changes neither the busy marks nor `busy_count`.
- R10: A granted buffer is never granted again before it has been released.
- R11: A granted allocation together with a release of a different busy buffer leaves `busy_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_req | input | 1 | Request one buffer this cycle |
| free_req | input | 1 | Release the buffer named by `free_idx` |
| free_idx | input | IDX_W (5) | Index of the buffer to release |
| nack | output | 1 | Allocation refused, pool full |
| alloc_idx | output | IDX_W (5) | Index of the buffer granted this cycle |
| busy_count | output | CNT_W (6) | Number of busy buffers, 0 to pool size |

## Verification
`nack` and `alloc_idx` come from combinational logic on the present busy marks and count. The bench therefore samples them one time unit after it drives the inputs on the falling edge, while still in the same cycle. Busy marks and the count change only at the rising edge. The bench computes the expected count before the edge and compares it one time unit after that edge. The effect of a release on `alloc_idx` is checked in the following cycle. A reference busy set, updated at the same edge, supplies the expected lowest index and detects a grant of a buffer that is still held.

// File: rtl/buf_alloc_pkg.sv
package buf_alloc_pkg;

    // Step applied to the occupancy counter at a clock edge
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_step_e;

    localparam int DEFAULT_NUM_BUF = 32;

endpackage

// File: rtl/buf_alloc_lowest_free.sv
module buf_alloc_lowest_free #(
    parameter int NUM_BUF = 32,
    parameter int IDX_W   = $clog2(NUM_BUF)
) (
    input  logic [NUM_BUF-1:0] busy_vec,
    output logic [IDX_W-1:0]   low_idx,
    output logic               any_idle
);

    // Scan from the top down so the lowest idle entry is written last
    always_comb begin
        low_idx  = '0;
        any_idle = 1'b0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (!busy_vec[i]) begin
                low_idx  = IDX_W'(i);
                any_idle = 1'b1;
            end
        end
    end

endmodule

// File: rtl/buf_alloc_busy_bits.sv
module buf_alloc_busy_bits #(
    parameter int NUM_BUF = 32,
    parameter int IDX_W   = $clog2(NUM_BUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_BUF-1:0] busy_vec
);

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        logic hit_set;
        logic hit_clr;

        assign hit_set = set_en && (set_idx == IDX_W'(g));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

        // Set is checked first: a grant overrides a release of the same slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_vec[g] <= 1'b0;
            end else if (hit_set) begin
                busy_vec[g] <= 1'b1;
            end else if (hit_clr) begin
                busy_vec[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/buf_alloc_counter.sv
module buf_alloc_counter
    import buf_alloc_pkg::*;
#(
    parameter int NUM_BUF = 32,
    parameter int CNT_W   = $clog2(NUM_BUF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_step_e        step,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (step)
                CNT_INC:  count <= count + CNT_W'(1);
                CNT_DEC:  count <= count - CNT_W'(1);
                default:  count <= count;
            endcase
        end
    end

endmodule

// File: rtl/buf_alloc_top.sv
module buf_alloc_top
    import buf_alloc_pkg::*;
#(
    parameter int  NUM_BUF = DEFAULT_NUM_BUF,
    localparam int IDX_W   = $clog2(NUM_BUF),
    localparam int CNT_W   = $clog2(NUM_BUF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             free_req,
    input  logic [IDX_W-1:0] free_idx,
    output logic             nack,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [CNT_W-1:0] busy_count
);

    logic [NUM_BUF-1:0] busy_vec;
    logic               any_idle;
    logic               grant;
    logic               release_busy;
    cnt_step_e          step;

    buf_alloc_lowest_free #(
        .NUM_BUF (NUM_BUF),
        .IDX_W   (IDX_W)
    ) u_scan (
        .busy_vec (busy_vec),
        .low_idx  (alloc_idx),
        .any_idle (any_idle)
    );

    assign nack         = alloc_req && (busy_count == CNT_W'(NUM_BUF));
    assign grant        = alloc_req && !nack;
    assign release_busy = free_req && busy_vec[free_idx];

    always_comb begin
        unique case ({grant, release_busy})
            2'b10:   step = CNT_INC;
            2'b01:   step = CNT_DEC;
            default: step = CNT_HOLD;
        endcase
    end

    buf_alloc_busy_bits #(
        .NUM_BUF (NUM_BUF),
        .IDX_W   (IDX_W)
    ) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (grant),
        .set_idx  (alloc_idx),
        .clr_en   (free_req),
        .clr_idx  (free_idx),
        .busy_vec (busy_vec)
    );

    buf_alloc_counter #(
        .NUM_BUF (NUM_BUF),
        .CNT_W   (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .count (busy_count)
    );

endmodule

// File: rtl/buf_alloc_checker.sv
module buf_alloc_checker #(
    parameter int NUM_BUF = 32,
    parameter int IDX_W   = $clog2(NUM_BUF),
    parameter int CNT_W   = $clog2(NUM_BUF + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_req,
    input logic             free_req,
    input logic [IDX_W-1:0] free_idx,
    input logic             nack,
    input logic [IDX_W-1:0] alloc_idx,
    input logic [CNT_W-1:0] busy_count
);

    logic [NUM_BUF-1:0] issued;
    logic               granted;

    assign granted = alloc_req && !nack;

    // Record of grants seen at the ports, used for the R10 check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued <= '0;
        end else begin
            if (free_req) issued[free_idx] <= 1'b0;
            if (granted)  issued[alloc_idx] <= 1'b1;
        end
    end

    assert_nack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nack |-> alloc_req);

    assert_nack_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && busy_count == CNT_W'(NUM_BUF)) |-> nack);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_count <= CNT_W'(NUM_BUF));

    assert_full_idx_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_count == CNT_W'(NUM_BUF)) |-> (alloc_idx == '0));

    assert_grant_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && !free_req) |=> (busy_count == $past(busy_count) + CNT_W'(1)));

    assert_refused_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nack && !free_req) |=> $stable(busy_count));

    assert_no_double_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> !issued[alloc_idx]);

endmodule

bind buf_alloc_top buf_alloc_checker #(
    .NUM_BUF (NUM_BUF)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_req),
    .free_req   (free_req),
    .free_idx   (free_idx),
    .nack       (nack),
    .alloc_idx  (alloc_idx),
    .busy_count (busy_count)
);

// File: tb/tb_buf_alloc_top.sv
`timescale 1ns/1ps
module tb_buf_alloc_top;

    localparam int N    = 32;
    localparam int IW   = $clog2(N);
    localparam int CW   = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic          free_req = 1'b0;
    logic [IW-1:0] free_idx = '0;
    logic          nack;
    logic [IW-1:0] alloc_idx;
    logic [CW-1:0] busy_count;

    int checks = 0;
    int errors = 0;
    bit mbusy [N];
    int mcount = 0;

    always #5 clk = ~clk;

    buf_alloc_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_req),
        .free_req   (free_req),
        .free_idx   (free_idx),
        .nack       (nack),
        .alloc_idx  (alloc_idx),
        .busy_count (busy_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int lowest_idle();
        for (int i = 0; i < N; i++) if (!mbusy[i]) return i;
        return 0;
    endfunction

    // One cycle: drive on falling edge, check combinational outputs,
    // then check the count one unit after the rising edge.
    task automatic step(input bit a, input bit f, input int fi);
        bit    exp_nack;
        bit    acc;
        bit    rel;
        int    exp_cnt;
        string creq;
        @(negedge clk);
        alloc_req = a;
        free_req  = f;
        free_idx  = IW'(fi);
        #1;
        exp_nack = a && (mcount == N);
        check("R2", int'(nack), int'(exp_nack));
        check(mcount == N ? "R4" : "R3", int'(alloc_idx), lowest_idle());
        acc = a && !exp_nack;
        if (acc) check("R10", int'(mbusy[alloc_idx]), 0);
        rel = f && mbusy[fi];
        exp_cnt = mcount + (acc ? 1 : 0) - (rel ? 1 : 0);
        if (acc && rel)   creq = "R11";
        else if (acc)     creq = "R5";
        else if (exp_nack) creq = "R9";
        else              creq = "R6";
        if (f) mbusy[fi] = 1'b0;
        if (acc) mbusy[alloc_idx] = 1'b1;
        mcount = exp_cnt;
        @(posedge clk);
        #1;
        check(creq, int'(busy_count), exp_cnt);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mbusy[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", int'(busy_count), 0);
        check("R1", int'(nack), 0);
        check("R1", int'(alloc_idx), 0);

        // Fill the whole pool: indices must come out 0,1,2,...
        for (int i = 0; i < N; i++) begin
            step(1'b1, 1'b0, 0);
        end
        check("R5", int'(busy_count), N);

        // Refused allocations while full
        step(1'b1, 1'b0, 0);
        step(1'b1, 1'b0, 0);

        // Release slot 5, it must then be offered (R7)
        step(1'b0, 1'b1, 5);
        #1;
        check("R7", int'(alloc_idx), 5);
        // Release the idle slot 5 again: count must not move (R6)
        step(1'b0, 1'b1, 5);
        check("R6", int'(busy_count), N - 1);

        // Grant and release slot 5 together: grant wins (R8)
        step(1'b1, 1'b1, 5);
        check("R8", int'(busy_count), N);
        step(1'b1, 1'b0, 0);
        check("R8", int'(nack), 1);

        // Release 3, then grant 3 while releasing busy 10 (R11)
        step(1'b0, 1'b1, 3);
        step(1'b1, 1'b1, 10);
        check("R11", int'(busy_count), N - 1);
        #1;
        check("R7", int'(alloc_idx), 10);

        // Sweep releases of every slot, high to low, then refill
        for (int i = N - 1; i >= 0; i--) step(1'b0, 1'b1, i);
        check("R6", int'(busy_count), 0);
        for (int i = 0; i < N; i += 2) step(1'b1, 1'b0, 0);
        for (int i = 0; i < N; i += 4) step(1'b0, 1'b1, i);

        // Mixed traffic, first filling-biased then draining-biased
        for (int c = 0; c < 4000; c++) begin
            int  pa = (c < 2000) ? 75 : 30;
            int  pf = (c < 2000) ? 30 : 75;
            bit  a  = ($urandom_range(99) < pa);
            bit  f  = ($urandom_range(99) < pf);
            int  fi = $urandom_range(N - 1);
            step(a, f, fi);
        end

        @(negedge clk);
        alloc_req = 1'b0;
        free_req  = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule